// File: doc/BRIEF.md
# Reset Pulse Qualifier with Strap Capture

This block takes an asynchronous reset request and turns it into a clean, clock-aligned core reset. It first brings the request into the clock domain. It then counts how many clock periods the request stays high. Only a request that lasts long enough is treated as a real reset. Very short glitches are dropped, and they leave the block exactly as it was.

When an accepted reset request ends, the block captures two strap inputs. The first strap asks for a built-in self-test. The second strap reports which type of coprocessor is attached. A self-test request is only honoured if the reset lasted much longer than the minimum. For a reset that is long enough to accept but too short for a self-test, the reset is still taken and the self-test flag is cleared.

The results are held on three flags until the next accepted reset. The rest of the chip reads these flags when it leaves reset.

Top module: `rst_qualifier`

## Requirements
- R1: The reset input passes through two flip-flops before it is measured. The pulse width is counted in whole clock periods of the synchronised signal. A request that is high for P rising edges measures as P.
- R2: For a pulse of width P with P >= MIN_W (default 15), `core_rst` is high for exactly P-14 clock cycles. It rises once the synchronised pulse has lasted MIN_W periods, and it falls one cycle after the synchronised input goes low.
- R3: A pulse shorter than MIN_W never raises `core_rst` and leaves all three flags unchanged. A single low synchronised sample restarts the width count from zero.
- R4: `rst_valid` is 0 after power-up. It becomes 1 at the end of the first accepted pulse and never returns to 0.
- R5: At the end of an accepted pulse of width at least SELFTEST_W (default 80), `selftest_req` takes the value of `strap_test` (1 = self-test requested).
- R6: At the end of an accepted pulse shorter than SELFTEST_W, the reset is still accepted and `selftest_req` is forced to 0, whatever `strap_test` is.
- R7: At the end of every accepted pulse, `cop_type` takes the value of `strap_cop`.
- R8: Both straps are taken at the rising edge where the reset input is first sampled low. Strap values held during the pulse, and values applied one cycle after release, are ignored.
- R9: The width counter saturates at SELFTEST_W. A pulse longer than that is handled like one of exactly SELFTEST_W, except that `core_rst` stays high for the whole pulse.
- R10: After power-up, with the reset input low, `core_rst`, `rst_valid`, `selftest_req` and `cop_type` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock used to measure the pulse width |
| rst_async | input | 1 | Asynchronous reset request, active high |
| strap_test | input | 1 | Self-test request strap, active high |
| strap_cop | input | 1 | Coprocessor type strap |
| core_rst | output | 1 | Qualified internal reset |
| rst_valid | output | 1 | Set once any reset has been accepted |
| selftest_req | output | 1 | Self-test request captured at the end of reset |
| cop_type | output | 1 | Coprocessor type captured at the end of reset |

## Verification
The hardest cases to reach from the ports are the exact pulse-width boundaries. Four widths matter most: 14 against 15, and 79 against 80. Each of them depends on the delay through the synchroniser. The bench holds the request high for a set number of rising edges, and it counts the cycles in which `core_rst` is high, so the measured width can be compared with P-14.

The strap capture instant is found by giving the straps the opposite value during the pulse, applying the wanted value at release, and inverting it again one cycle later. A pulse that is split by a single low cycle shows whether the width count really restarts.

// File: rtl/rst_qualifier.sv
module rst_qualifier #(
  parameter int MIN_W      = 15,
  parameter int SELFTEST_W = 80
) (
  input  logic clk,
  input  logic rst_async,
  input  logic strap_test,
  input  logic strap_cop,
  output logic core_rst,
  output logic rst_valid,
  output logic selftest_req,
  output logic cop_type
);

  localparam int CNT_W = $clog2(SELFTEST_W + 1);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_W);
  localparam logic [CNT_W-1:0] SAT_C = CNT_W'(SELFTEST_W);

  logic [1:0]       rst_s = '0;
  logic [1:0]       tst_s = '0;
  logic [1:0]       cop_s = '0;
  logic             rst_d = 1'b0;
  logic [CNT_W-1:0] cnt   = '0;
  logic             valid_q = 1'b0;
  logic             st_q    = 1'b0;
  logic             cop_q   = 1'b0;
  logic             armed   = 1'b0;

  logic fall, long_enough, at_sat;

  assign fall        = rst_d & ~rst_s[1];
  assign long_enough = cnt >= MIN_C;
  assign at_sat      = cnt == SAT_C;

  always_ff @(posedge clk) begin
    rst_s <= {rst_s[0], rst_async};
    tst_s <= {tst_s[0], strap_test};
    cop_s <= {cop_s[0], strap_cop};
    rst_d <= rst_s[1];
    armed <= 1'b1;
    if (!rst_s[1])
      cnt <= '0;
    else if (!at_sat)
      cnt <= cnt + 1'b1;
    if (fall && long_enough) begin
      valid_q <= 1'b1;
      st_q    <= tst_s[1] & at_sat;
      cop_q   <= cop_s[1];
    end
  end

  assign core_rst     = long_enough;
  assign rst_valid    = valid_q;
  assign selftest_req = st_q;
  assign cop_type     = cop_q;

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!armed)
    cnt <= SAT_C);

  assert_short_ignored_R3: assert property (@(posedge clk) disable iff (!armed)
    (fall && !long_enough) |=> ($stable(valid_q) && $stable(st_q) && $stable(cop_q)));

  assert_valid_sticky_R4: assert property (@(posedge clk) disable iff (!armed)
    !$fell(valid_q));

  assert_selftest_long_R6: assert property (@(posedge clk) disable iff (!armed)
    $rose(st_q) |-> $past(cnt) == SAT_C);

  assert_core_rst_onset_R2: assert property (@(posedge clk) disable iff (!armed)
    $rose(core_rst) |-> ($past(cnt) == MIN_C - 1'b1 && $past(rst_s[1])));

endmodule

// File: tb/tb_rst_qualifier.sv
module tb_rst_qualifier;
  logic clk = 1'b0;
  logic rst_async = 1'b0, strap_test = 1'b0, strap_cop = 1'b0;
  logic core_rst, rst_valid, selftest_req, cop_type;
  int tests = 0, fails = 0, hi_cycles = 0;
  bit counting = 1'b0;

  always #4 clk = ~clk;

  rst_qualifier dut (.clk(clk), .rst_async(rst_async), .strap_test(strap_test),
    .strap_cop(strap_cop), .core_rst(core_rst), .rst_valid(rst_valid),
    .selftest_req(selftest_req), .cop_type(cop_type));

  always @(negedge clk) if (counting && core_rst) hi_cycles++;

  localparam int N = 9;
  localparam int PW  [N] = '{14, 15, 40, 79, 80,  3, 200, 14, 100};
  localparam bit TST [N] = '{ 1,  0,  1,  1,  1,  0,   1,  0,   0};
  localparam bit COP [N] = '{ 1,  1,  0,  1,  0,  1,   1,  0,   0};
  localparam bit EV  [N] = '{ 0,  1,  1,  1,  1,  1,   1,  1,   1};
  localparam bit EST [N] = '{ 0,  0,  0,  0,  1,  1,   1,  1,   0};
  localparam bit ECOP[N] = '{ 0,  1,  0,  1,  0,  0,   1,  1,   0};
  localparam int EHI [N] = '{ 0,  1, 26, 65, 66,  0, 186,  0,  86};

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Straps are wrong during the pulse, right at release, inverted one cycle later (R8).
  task automatic pulse(int p, bit t, bit c);
    @(negedge clk);
    hi_cycles = 0; counting = 1'b1;
    strap_test = ~t; strap_cop = ~c; rst_async = 1'b1;
    repeat (p) @(negedge clk);
    rst_async = 1'b0; strap_test = t; strap_cop = c;
    @(negedge clk);
    strap_test = ~t; strap_cop = ~c;
    repeat (6) @(negedge clk);
    counting = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R10 core_rst", core_rst, 0);
    chk("R10 rst_valid", rst_valid, 0);
    chk("R10 selftest_req", selftest_req, 0);
    chk("R10 cop_type", cop_type, 0);

    for (int i = 0; i < N; i++) begin
      pulse(PW[i], TST[i], COP[i]);
      chk("R2 R3 R9 core_rst cycles", hi_cycles, EHI[i]);
      chk("R4 rst_valid", rst_valid, EV[i]);
      chk("R5 R6 selftest_req", selftest_req, EST[i]);
      chk("R7 R8 cop_type", cop_type, ECOP[i]);
    end

    // R3: two 10-cycle halves split by one low cycle must not add up.
    @(negedge clk);
    hi_cycles = 0; counting = 1'b1;
    strap_test = 1'b1; strap_cop = 1'b1; rst_async = 1'b1;
    repeat (10) @(negedge clk);
    rst_async = 1'b0;
    @(negedge clk);
    rst_async = 1'b1;
    repeat (10) @(negedge clk);
    rst_async = 1'b0;
    repeat (8) @(negedge clk);
    counting = 1'b0;
    chk("R3 split pulse core_rst", hi_cycles, 0);
    chk("R3 split pulse selftest_req", selftest_req, 0);
    chk("R3 split pulse cop_type", cop_type, 0);

    // R1: core_rst onset at rising edge MIN_W+2 after the request goes high.
    @(negedge clk);
    rst_async = 1'b1; strap_test = 1'b0; strap_cop = 1'b0;
    repeat (16) @(negedge clk);
    chk("R1 core_rst low after 16 edges", core_rst, 0);
    @(negedge clk);
    chk("R1 core_rst high after 17 edges", core_rst, 1);
    rst_async = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 core_rst held to end of sync pulse", core_rst, 1);
    @(negedge clk);
    chk("R2 core_rst released", core_rst, 0);
    chk("R6 short pulse selftest low", selftest_req, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule